// File: doc/BRIEF.md
# CPU Speed-Request Snoop and Input-Clock Select

This block sits on the CPU bus in front of a synchronous memory controller. The controller has a set of speed-request addresses that would normally change its internal divider. When the divider changes, the controller stops sharing memory with video and stops refreshing the DRAM. This block watches every CPU write. It recognises writes to the four speed-request addresses and records the requested rate in two mode bits of its own. It masks those writes so they never reach the controller. The controller therefore stays in its slow divider, with normal video multiplexing and refresh.

To give the requested speed-up, the block drives a registered select that chooses the controller's input timebase. A value of 0 selects the base rate, nominally 14.31818 MHz. A value of 1 selects the doubled rate, nominally 28.63636 MHz. With the doubled rate, the CPU clock goes from 0.89 MHz to 1.78 MHz and the video clock from 3.58 MHz to 7.16 MHz. The write data plays no part; only the address decides the effect.

The select changes only on a bus-cycle boundary. A boundary is a clock edge at which the bus-cycle qualifier is low after being high on the edge before. A four-state machine governs the change:
- States: `SEL_BASE`, `SEL_ARM_UP`, `SEL_DOUBLE`, `SEL_ARM_DOWN`.
- Transitions:
  - `SEL_BASE`→`SEL_ARM_UP` when the doubled rate is wanted.
  - `SEL_ARM_UP`→`SEL_DOUBLE` on a boundary while it is still wanted.
  - `SEL_ARM_UP`→`SEL_BASE` (cancel) when the request is withdrawn.
  - `SEL_DOUBLE`→`SEL_ARM_DOWN` when it is no longer wanted.
  - `SEL_ARM_DOWN`→`SEL_BASE` on a boundary while it is still unwanted.
  - `SEL_ARM_DOWN`→`SEL_DOUBLE` (cancel) when it is wanted again.

Top module: `clkmode_snoop`

## Requirements
- R1: After reset, `mode_status` is 3'b000 and `clk_sel` is 0 (base rate).
- R2: When `bus_wr` is 1 and `bus_addr` is in 0xFFD6..0xFFD9, `ctl_wr_en` is 0 in the same cycle, whatever the value of `bus_qual`.
- R3: For any other address, including the rest of 0xFFC0..0xFFDF, `ctl_wr_en` equals `bus_wr` in the same cycle.
- R4: A speed write takes effect only if `bus_wr` and `bus_qual` are both 1 at the same clock edge. Otherwise the mode bits are left unchanged.
- R5: The four addresses act on the mode bits as follows:
  - 0xFFD6 clears bit0 and 0xFFD7 sets it.
  - 0xFFD8 clears bit1 and 0xFFD9 sets it.
  - `mode_status` is {clk_sel, bit1, bit0}, at positions [2], [1] and [0].
  - The bits show the new value from the clock edge that takes the write.
- R6: The doubled rate is wanted while bit0 or bit1 is 1. The base rate returns only once both bits are 0.
- R7: `clk_sel` changes only at a boundary edge. That edge is at least one edge after the mode bits changed. While `bus_qual` stays high, `clk_sel` holds.
- R8: If the request returns to the current rate before a boundary, `clk_sel` never changes.
- R9: Repeated writes to the same address leave the mode bits and `clk_sel` as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | CPU address |
| bus_wr | input | 1 | CPU write strobe |
| bus_qual | input | 1 | Bus-cycle qualifier; its falling edge marks a cycle boundary |
| ctl_wr_en | output | 1 | Write enable passed to the memory controller |
| clk_sel | output | 1 | Input-timebase select: 0 base, 1 doubled |
| mode_status | output | 3 | {clk_sel, bit1, bit0} |

## Verification
Each result is due at a different point after its stimulus:
- `ctl_wr_en` is combinational. The bench checks it 1 ns after driving the address, within the same cycle.
- The mode bits are due at the edge that takes the write. The bench reads them at the following falling edge.
- `clk_sel` needs one edge to arm and then a boundary edge. The bench holds `bus_qual` high first to confirm the select has not moved. It then drops `bus_qual` for one edge and reads the select at the falling edge after that boundary.

// File: rtl/clkmode_pkg.sv
`timescale 1ns/1ps
package clkmode_pkg;
    typedef enum logic [1:0] {
        SEL_BASE     = 2'd0,
        SEL_ARM_UP   = 2'd1,
        SEL_DOUBLE   = 2'd2,
        SEL_ARM_DOWN = 2'd3
    } sel_state_e;

    localparam logic [15:0] SPEED_ADDR_LO = 16'hFFD6;
    localparam int          SPEED_BITS    = 2;
endpackage

// File: rtl/speed_decode.sv
`timescale 1ns/1ps
module speed_decode #(
    parameter int               ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE  = 16'hFFD6,
    parameter int               SPAN   = 4,
    localparam int              IDX_W  = $clog2(SPAN)
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_qual,
    output logic              ctl_wr_en,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);
    logic [ADDR_W-1:0] offset;
    logic              in_window;

    always_comb begin
        offset    = bus_addr - BASE;
        in_window = (bus_addr >= BASE) && (offset < ADDR_W'(SPAN));
        hit_idx   = offset[IDX_W-1:0];
        hit       = in_window && bus_wr && bus_qual;
        ctl_wr_en = bus_wr && !in_window;
    end
endmodule

// File: rtl/mode_bits.sv
`timescale 1ns/1ps
module mode_bits #(
    parameter int  NBITS = 2,
    localparam int IDX_W = $clog2(2 * NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_idx,
    output logic [NBITS-1:0] bits,
    output logic             want_fast
);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        localparam logic [IDX_W-2:0] SLOT = (IDX_W-1)'(i);
        logic touch;
        assign touch = hit && (hit_idx[IDX_W-1:1] == SLOT);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     bits[i] <= 1'b0;
            else if (touch) bits[i] <= hit_idx[0];
        end
    end

    assign want_fast = |bits;
endmodule

// File: rtl/sel_handover.sv
`timescale 1ns/1ps
module sel_handover
    import clkmode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_fast,
    input  logic bus_qual,
    output logic clk_sel
);
    sel_state_e state, nxt;
    logic       qual_d;
    logic       boundary;

    assign boundary = qual_d && !bus_qual;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qual_d <= 1'b0;
        else        qual_d <= bus_qual;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SEL_BASE:     if (want_fast)  nxt = SEL_ARM_UP;
            SEL_ARM_UP:   if (!want_fast) nxt = SEL_BASE;
                          else if (boundary) nxt = SEL_DOUBLE;
            SEL_DOUBLE:   if (!want_fast) nxt = SEL_ARM_DOWN;
            SEL_ARM_DOWN: if (want_fast)  nxt = SEL_DOUBLE;
                          else if (boundary) nxt = SEL_BASE;
            default:      nxt = SEL_BASE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEL_BASE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_sel <= 1'b0;
        else        clk_sel <= (nxt == SEL_DOUBLE) || (nxt == SEL_ARM_DOWN);
    end
endmodule

// File: rtl/clkmode_snoop.sv
`timescale 1ns/1ps
module clkmode_snoop #(
    parameter int               ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] SPEED_BASE = clkmode_pkg::SPEED_ADDR_LO,
    parameter int               MODE_BITS  = clkmode_pkg::SPEED_BITS,
    localparam int              SPAN       = 2 * MODE_BITS,
    localparam int              IDX_W      = $clog2(SPAN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_qual,
    output logic                 ctl_wr_en,
    output logic                 clk_sel,
    output logic [MODE_BITS:0]   mode_status
);
    logic                 hit;
    logic [IDX_W-1:0]     hit_idx;
    logic [MODE_BITS-1:0] bits;
    logic                 want_fast;

    speed_decode #(.ADDR_W(ADDR_W), .BASE(SPEED_BASE), .SPAN(SPAN)) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_qual (bus_qual),
        .ctl_wr_en(ctl_wr_en),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    mode_bits #(.NBITS(MODE_BITS)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .bits     (bits),
        .want_fast(want_fast)
    );

    sel_handover u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .want_fast(want_fast),
        .bus_qual (bus_qual),
        .clk_sel  (clk_sel)
    );

    assign mode_status = {clk_sel, bits};
endmodule

// File: rtl/clkmode_snoop_chk.sv
`timescale 1ns/1ps
module clkmode_snoop_chk #(
    parameter logic [15:0] BASE = 16'hFFD6
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic        bus_wr,
    input logic        bus_qual,
    input logic        ctl_wr_en,
    input logic        clk_sel,
    input logic [2:0]  mode_status
);
    logic speed_a;
    assign speed_a = (bus_addr >= BASE) && (bus_addr <= BASE + 16'd3);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_status == 3'b000)); // R1
    AST_SPEED_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && speed_a) |-> !ctl_wr_en); // R2
    AST_OTHER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !speed_a |-> (ctl_wr_en == bus_wr)); // R3
    AST_UNQUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_a && !(bus_wr && bus_qual)) |=> (mode_status[1:0] == $past(mode_status[1:0]))); // R4
    AST_SET_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_qual && bus_addr == BASE + 16'd1) |=> mode_status[0]); // R5
    AST_CLR_BIT1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_qual && bus_addr == BASE + 16'd2) |=> !mode_status[1]); // R5
    AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_sel) |-> ($past(mode_status[1:0]) == 2'b00)); // R6
    AST_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_sel) |-> ($past(mode_status[1:0]) != 2'b00)); // R6
    AST_SEL_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_sel) |-> ($past(bus_qual, 2) && !$past(bus_qual))); // R7
endmodule

bind clkmode_snoop clkmode_snoop_chk #(.BASE(SPEED_BASE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_qual   (bus_qual),
    .ctl_wr_en  (ctl_wr_en),
    .clk_sel    (clk_sel),
    .mode_status(mode_status)
);

// File: tb/tb_clkmode_snoop.sv
`timescale 1ns/1ps
module tb_clkmode_snoop;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic        bus_qual = 1'b1;
    logic        ctl_wr_en;
    logic        clk_sel;
    logic [2:0]  mode_status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clkmode_snoop dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_qual(bus_qual), .ctl_wr_en(ctl_wr_en), .clk_sel(clk_sel),
        .mode_status(mode_status)
    );

    // {addr, wr, qual, expected ctl_wr_en, expected bits}
    localparam int NV = 18;
    localparam logic [20:0] VEC [0:NV-1] = '{
        {16'hFFD7, 1'b1, 1'b1, 1'b0, 2'b01},
        {16'hFFD7, 1'b1, 1'b1, 1'b0, 2'b01},
        {16'hFFD9, 1'b1, 1'b1, 1'b0, 2'b11},
        {16'hFFD6, 1'b1, 1'b1, 1'b0, 2'b10},
        {16'hFFD6, 1'b1, 1'b1, 1'b0, 2'b10},
        {16'hFFD8, 1'b1, 1'b1, 1'b0, 2'b00},
        {16'hFFD9, 1'b1, 1'b1, 1'b0, 2'b10},
        {16'hFFD8, 1'b1, 1'b0, 1'b0, 2'b10},
        {16'hFFD8, 1'b0, 1'b1, 1'b0, 2'b10},
        {16'hFFD5, 1'b1, 1'b1, 1'b1, 2'b10},
        {16'hFFDA, 1'b1, 1'b1, 1'b1, 2'b10},
        {16'hFFC0, 1'b1, 1'b1, 1'b1, 2'b10},
        {16'hFFDF, 1'b1, 1'b1, 1'b1, 2'b10},
        {16'h1234, 1'b1, 1'b1, 1'b1, 2'b10},
        {16'hFFD8, 1'b1, 1'b1, 1'b0, 2'b00},
        {16'hFFD7, 1'b1, 1'b1, 1'b0, 2'b01},
        {16'hFFD8, 1'b1, 1'b1, 1'b0, 2'b01},
        {16'hFFD6, 1'b1, 1'b1, 1'b0, 2'b00}
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; bus_qual = 1'b1; bus_addr = 16'h0000;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic spd_write(input logic [15:0] a);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_qual = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 16'h0000;
    endtask

    task automatic boundary();
        @(posedge clk);
        @(negedge clk);
        bus_qual = 1'b0;
        @(posedge clk);
        @(negedge clk);
        bus_qual = 1'b1;
    endtask

    initial begin
        do_reset();
        check("R1 reset status", mode_status, 3'b000);
        check("R1 reset select", {2'b00, clk_sel}, 3'b000);

        foreach (VEC[i]) begin
            @(negedge clk);
            bus_addr = VEC[i][20:5]; bus_wr = VEC[i][4]; bus_qual = VEC[i][3];
            #1;
            check(VEC[i][2] ? "R3 pass-through" : "R2 hidden write",
                  {2'b00, ctl_wr_en}, {2'b00, VEC[i][2]});
            @(posedge clk);
            @(negedge clk);
            check("R4 R5 R9 mode bits", {1'b0, mode_status[1:0]}, {1'b0, VEC[i][1:0]});
            bus_wr = 1'b0; bus_qual = 1'b1;
        end

        // R7: arm, hold, then switch on boundary
        do_reset();
        spd_write(16'hFFD7);
        check("R5 bit0 set", mode_status, 3'b001);
        repeat (4) @(negedge clk);
        check("R7 hold while qual high", {2'b00, clk_sel}, 3'b000);
        boundary();
        check("R7 switch on boundary", mode_status, 3'b101);

        // R6: partial clear keeps doubled rate
        spd_write(16'hFFD9);
        spd_write(16'hFFD6);
        boundary();
        check("R6 one bit still set", mode_status, 3'b110);
        spd_write(16'hFFD8);
        check("R6 both cleared, before boundary", mode_status, 3'b100);
        boundary();
        check("R6 base after both cleared", mode_status, 3'b000);

        // R8: request withdrawn before boundary
        spd_write(16'hFFD7);
        spd_write(16'hFFD6);
        boundary();
        check("R8 cancel up", mode_status, 3'b000);
        spd_write(16'hFFD9);
        boundary();
        check("R7 up again", mode_status, 3'b110);
        spd_write(16'hFFD8);
        spd_write(16'hFFD9);
        boundary();
        check("R8 cancel down", mode_status, 3'b110);

        // R9: repeat same write, no change
        spd_write(16'hFFD9);
        boundary();
        check("R9 repeat set", mode_status, 3'b110);

        // R1: reset in doubled mode
        do_reset();
        check("R1 reset from doubled", mode_status, 3'b000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule